// File: doc/BRIEF.md
# Brownout Reset Sequencing Controller

This block drives a pair of complementary reset outputs for a host processor from a filtered supply-good comparator input. It runs from a slow free-running clock. While the supply is invalid it holds reset. The release is timed differently for a cold start and for a dip after normal operation.

After a cold start, reset drops once the supply has been valid for a set number of consecutive cycles. After a brownout, the same valid-supply delay applies, and a minimum total reset length also applies, counted from the cycle the dip was seen. Whichever of the two ends later decides the release. A clock-ready output rises a fixed number of cycles ahead of the release, so the host's own start-up logic sees a stable clock.

The block also holds a 6-bit threshold code for the external comparator. The code can be locked until the next power cycle. Two sticky cause flags record whether the last reset came from power-up or from a brownout.

Top module: `supply_reset_seq`

## Requirements
- R1: While `por_n` is low, the outputs take these values: `rst_hi`=1, `rst_lo_n`=0, `clk_ready`=0, `thr_code`=DEFAULT_CODE, `thr_locked`=0, `cause_por`=1 and `cause_bo`=0.
- R2: `rst_lo_n` is always the complement of `rst_hi`.
- R3: At any clock edge where `supply_ok` is sampled low, `rst_hi` is 1 after that edge. If reset had been released, that edge is the brownout edge.
- R4: After power-up, `rst_hi` falls at the edge that samples `supply_ok` high for the VALID_CYC-th consecutive time.
- R5: After a brownout, two conditions must both hold before reset is released. The edge must sample the VALID_CYC-th consecutive high. It must also come at least MIN_CYC edges after the brownout edge. The later of the two deadlines wins.
- R6: A low sample on `supply_ok` during the countdown restarts the consecutive-valid count. It does not move the brownout start, which is captured only while reset is released.
- R7: `clk_ready` rises at the edge that samples the (VALID_CYC-LEAD_CYC)-th consecutive high, or at release, whichever comes first. It stays high while reset is released and falls at any edge that samples `supply_ok` low.
- R8: Threshold code writes work as follows. A pulse on `thr_we` while unlocked loads `cfg_wdata` into `thr_code` at that edge.
- R9: Control writes work as follows. A pulse on `ctl_we` with `cfg_wdata` bit 0 set sets `thr_locked`. Once it is set, `thr_we` has no effect on `thr_code`, and no write clears `thr_locked`. Only `por_n` clears it.
- R10: `cause_bo` is set at the brownout edge. A control write with bit 1 set clears `cause_por`, and one with bit 2 set clears `cause_bo`. A brownout wins over a clear of `cause_bo` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow free-running clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Filtered supply-valid comparator result |
| thr_we | input | 1 | Threshold code write strobe |
| ctl_we | input | 1 | Control write strobe (lock set, flag clears) |
| cfg_wdata | input | CODE_W | Write data shared by both strobes |
| rst_hi | output | 1 | Reset to host, active high |
| rst_lo_n | output | 1 | Reset to host, active low |
| clk_ready | output | 1 | Clock valid indication ahead of release |
| thr_code | output | CODE_W | Brownout threshold code (0 is lowest) |
| thr_locked | output | 1 | Threshold code write lock |
| cause_por | output | 1 | Sticky flag for a power-up reset |
| cause_bo | output | 1 | Sticky flag for a brownout reset |

## Verification
A bad count register shows up at the ports as a release on the wrong edge. An off-by-one shows within one cycle of the expected falling edge of `rst_hi`. A missed brownout start shows only after a short dip, when the minimum length should dominate. A wrong `clk_ready` threshold moves its rising edge by the same number of cycles, and the lead checker notices it at the following release. Lock and flag faults are visible on the next edge after the offending write. The bench therefore places writes right on brownout edges and while locked.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

    localparam int CTL_LOCK_BIT    = 0;
    localparam int CTL_CLR_POR_BIT = 1;
    localparam int CTL_CLR_BO_BIT  = 2;
endpackage

// File: rtl/srs_sat_counter.sv
module srs_sat_counter #(
    parameter int MAX = 197,
    parameter int W   = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         clr,
    input  logic         set_one,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = W'(MAX);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clr) begin
            nxt_d.cnt = '0;
        end else if (set_one) begin
            nxt_d.cnt = W'(1);
        end else if (inc && (cur_q.cnt < TOP)) begin
            nxt_d.cnt = cur_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cnt = cur_q.cnt;
endmodule

// File: rtl/srs_cfg_regs.sv
module srs_cfg_regs
    import srs_pkg::*;
#(
    parameter int              CODE_W       = 6,
    parameter logic [CODE_W-1:0] DEFAULT_CODE = CODE_W'(20)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              thr_we,
    input  logic              ctl_we,
    input  logic [CODE_W-1:0] wdata,
    input  logic              bo_event,
    output logic [CODE_W-1:0] thr_code,
    output logic              locked,
    output logic              cause_por,
    output logic              cause_bo
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              locked;
        logic              por;
        logic              bo;
    } cfg_t;

    localparam cfg_t CFG_RST = '{code: DEFAULT_CODE, locked: 1'b0, por: 1'b1, bo: 1'b0};

    cfg_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (thr_we && !cur_q.locked) begin
            nxt_d.code = wdata;
        end
        if (ctl_we) begin
            if (wdata[CTL_LOCK_BIT])    nxt_d.locked = 1'b1;
            if (wdata[CTL_CLR_POR_BIT]) nxt_d.por    = 1'b0;
            if (wdata[CTL_CLR_BO_BIT])  nxt_d.bo     = 1'b0;
        end
        if (bo_event) begin
            nxt_d.bo = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cur_q <= CFG_RST;
        else        cur_q <= nxt_d;
    end

    assign thr_code  = cur_q.code;
    assign locked    = cur_q.locked;
    assign cause_por = cur_q.por;
    assign cause_bo  = cur_q.bo;
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
    import srs_pkg::*;
#(
    parameter int                CODE_W       = 6,
    parameter logic [CODE_W-1:0] DEFAULT_CODE = CODE_W'(20),
    parameter int                VALID_CYC    = 197,
    parameter int                MIN_CYC      = 393,
    parameter int                LEAD_CYC     = 66
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              supply_ok,
    input  logic              thr_we,
    input  logic              ctl_we,
    input  logic [CODE_W-1:0] cfg_wdata,
    output logic              rst_hi,
    output logic              rst_lo_n,
    output logic              clk_ready,
    output logic [CODE_W-1:0] thr_code,
    output logic              thr_locked,
    output logic              cause_por,
    output logic              cause_bo
);
    localparam int VCNT_W = $clog2(VALID_CYC + 1);
    localparam int BCNT_W = $clog2(MIN_CYC + 1);
    localparam logic [VCNT_W-1:0] REL_MARK  = VCNT_W'(VALID_CYC - 1);
    localparam logic [VCNT_W-1:0] LEAD_MARK = VCNT_W'(VALID_CYC - LEAD_CYC - 1);
    localparam logic [BCNT_W-1:0] MIN_MARK  = BCNT_W'(MIN_CYC);

    typedef struct packed {
        seq_state_e state;
        logic       cold;
        logic       rst;
        logic       clk_rdy;
    } seq_t;

    localparam seq_t SEQ_RST = '{state: ST_HOLD, cold: 1'b1, rst: 1'b1, clk_rdy: 1'b0};

    seq_t cur_q, nxt_d;

    logic              valid_clr, valid_inc;
    logic              bo_set, bo_inc, bo_event;
    logic [VCNT_W-1:0] valid_cnt;
    logic [BCNT_W-1:0] bo_cnt;

    always_comb begin
        nxt_d     = cur_q;
        valid_clr = 1'b0;
        valid_inc = 1'b0;
        bo_set    = 1'b0;
        bo_inc    = 1'b0;
        bo_event  = 1'b0;
        case (cur_q.state)
            ST_RUN: begin
                valid_clr = 1'b1;
                if (!supply_ok) begin
                    bo_event      = 1'b1;
                    bo_set        = 1'b1;
                    nxt_d.state   = ST_HOLD;
                    nxt_d.cold    = 1'b0;
                    nxt_d.rst     = 1'b1;
                    nxt_d.clk_rdy = 1'b0;
                end
            end
            default: begin
                bo_inc = !cur_q.cold;
                if (!supply_ok) begin
                    valid_clr     = 1'b1;
                    nxt_d.state   = ST_HOLD;
                    nxt_d.clk_rdy = 1'b0;
                end else begin
                    valid_inc     = 1'b1;
                    nxt_d.state   = ST_WAIT;
                    nxt_d.clk_rdy = (valid_cnt >= LEAD_MARK);
                    if ((valid_cnt >= REL_MARK) && (cur_q.cold || (bo_cnt >= MIN_MARK))) begin
                        nxt_d.state   = ST_RUN;
                        nxt_d.rst     = 1'b0;
                        nxt_d.clk_rdy = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cur_q <= SEQ_RST;
        else        cur_q <= nxt_d;
    end

    srs_sat_counter #(.MAX(VALID_CYC), .W(VCNT_W)) u_valid_cnt (
        .clk     (clk),
        .por_n   (por_n),
        .clr     (valid_clr),
        .set_one (1'b0),
        .inc     (valid_inc),
        .cnt     (valid_cnt)
    );

    srs_sat_counter #(.MAX(MIN_CYC), .W(BCNT_W)) u_bo_cnt (
        .clk     (clk),
        .por_n   (por_n),
        .clr     (1'b0),
        .set_one (bo_set),
        .inc     (bo_inc),
        .cnt     (bo_cnt)
    );

    srs_cfg_regs #(.CODE_W(CODE_W), .DEFAULT_CODE(DEFAULT_CODE)) u_cfg (
        .clk       (clk),
        .por_n     (por_n),
        .thr_we    (thr_we),
        .ctl_we    (ctl_we),
        .wdata     (cfg_wdata),
        .bo_event  (bo_event),
        .thr_code  (thr_code),
        .locked    (thr_locked),
        .cause_por (cause_por),
        .cause_bo  (cause_bo)
    );

    assign rst_hi    = cur_q.rst;
    assign rst_lo_n  = ~cur_q.rst;
    assign clk_ready = cur_q.clk_rdy;
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
    parameter int CODE_W    = 6,
    parameter int MIN_CYC   = 393,
    parameter int LEAD_CYC  = 66
) (
    input logic              clk,
    input logic              por_n,
    input logic              supply_ok,
    input logic              rst_hi,
    input logic              rst_lo_n,
    input logic              clk_ready,
    input logic [CODE_W-1:0] thr_code,
    input logic              thr_locked,
    input logic              cause_bo
);
    logic [31:0] rst_len;
    logic [31:0] rdy_len;
    logic        rst_prev;
    logic        bo_seen;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rst_len  <= '0;
            rdy_len  <= '0;
            rst_prev <= 1'b1;
            bo_seen  <= 1'b0;
        end else begin
            rst_prev <= rst_hi;
            rst_len  <= rst_hi ? rst_len + 32'd1 : 32'd0;
            rdy_len  <= (rst_hi && clk_ready) ? rdy_len + 32'd1 : 32'd0;
            if (rst_hi && !rst_prev) bo_seen <= 1'b1;
        end
    end

    AST_RST_PAIR: assert property (@(posedge clk) disable iff (!por_n)
        rst_lo_n == !rst_hi); // R2
    AST_LOW_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        !supply_ok |=> rst_hi); // R3
    AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_hi) |-> $past(supply_ok)); // R4
    AST_BO_MIN_LEN: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(rst_hi) && bo_seen) |-> (rst_len >= 32'(MIN_CYC))); // R5
    AST_CLKRDY_LEAD: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_hi) |-> (rdy_len >= 32'(LEAD_CYC))); // R7
    AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
        thr_locked |=> $stable(thr_code)); // R9
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        thr_locked |=> thr_locked); // R9
    AST_BO_FLAG_SET: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_hi) |-> cause_bo); // R10
endmodule

bind supply_reset_seq srs_chk #(
    .CODE_W   (CODE_W),
    .MIN_CYC  (MIN_CYC),
    .LEAD_CYC (LEAD_CYC)
) u_srs_chk (
    .clk        (clk),
    .por_n      (por_n),
    .supply_ok  (supply_ok),
    .rst_hi     (rst_hi),
    .rst_lo_n   (rst_lo_n),
    .clk_ready  (clk_ready),
    .thr_code   (thr_code),
    .thr_locked (thr_locked),
    .cause_bo   (cause_bo)
);

// File: tb/supply_reset_seq_bench.sv
module supply_reset_seq_bench;
    localparam int CW   = 6;
    localparam int TV   = 12;
    localparam int TM   = 25;
    localparam int TL   = 4;
    localparam int DEFC = 20;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          supply_ok = 1'b0;
    logic          thr_we = 1'b0;
    logic          ctl_we = 1'b0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          rst_hi, rst_lo_n, clk_ready, thr_locked, cause_por, cause_bo;
    logic [CW-1:0] thr_code;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    supply_reset_seq #(
        .CODE_W(CW), .DEFAULT_CODE(CW'(DEFC)),
        .VALID_CYC(TV), .MIN_CYC(TM), .LEAD_CYC(TL)
    ) u_supply_reset_seq (
        .clk(clk), .por_n(por_n), .supply_ok(supply_ok),
        .thr_we(thr_we), .ctl_we(ctl_we), .cfg_wdata(cfg_wdata),
        .rst_hi(rst_hi), .rst_lo_n(rst_lo_n), .clk_ready(clk_ready),
        .thr_code(thr_code), .thr_locked(thr_locked),
        .cause_por(cause_por), .cause_bo(cause_bo)
    );

    // behavioural reference
    bit m_released, m_cold, m_rdy, m_lock, m_fpor, m_fbo, m_low_seen;
    int m_valid, m_since, m_code;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_released = 0; m_cold = 1; m_rdy = 0; m_lock = 0;
            m_fpor = 1; m_fbo = 0; m_valid = 0; m_since = 0;
            m_code = DEFC; m_low_seen = 0;
        end else begin
            bit brown;
            brown = m_released && !supply_ok;
            m_low_seen = !supply_ok;
            if (thr_we && !m_lock) m_code = int'(cfg_wdata);
            if (ctl_we) begin
                if (cfg_wdata[0]) m_lock = 1;
                if (cfg_wdata[1]) m_fpor = 0;
                if (cfg_wdata[2]) m_fbo  = 0;
            end
            if (m_released) begin
                if (brown) begin
                    m_released = 0; m_cold = 0; m_since = 1;
                    m_valid = 0; m_rdy = 0; m_fbo = 1;
                end
            end else begin
                int old_since;
                old_since = m_since;
                if (!m_cold) m_since++;
                m_valid = supply_ok ? m_valid + 1 : 0;
                m_rdy = supply_ok && (m_valid >= TV - TL);
                if (m_valid >= TV && (m_cold || old_since >= TM)) begin
                    m_released = 1; m_rdy = 1;
                end
            end
        end
    end

    task automatic check(string tag, string sig, int act, int exp);
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, sig, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        string rtag;
        vectors++;
        if (!por_n)          rtag = "R1";
        else if (m_low_seen) rtag = "R3";
        else if (m_cold)     rtag = "R4 R6";
        else                 rtag = "R5 R6";
        check(rtag, "rst_hi", int'(rst_hi), int'(!m_released));
        check(!por_n ? "R1" : "R2", "rst_lo_n", int'(rst_lo_n), int'(m_released));
        check(!por_n ? "R1" : "R7", "clk_ready", int'(clk_ready), int'(m_rdy));
        check(!por_n ? "R1" : "R8 R9", "thr_code", int'(thr_code), m_code);
        check(!por_n ? "R1" : "R9", "thr_locked", int'(thr_locked), int'(m_lock));
        check(!por_n ? "R1" : "R10", "cause_por", int'(cause_por), int'(m_fpor));
        check(!por_n ? "R1" : "R10", "cause_bo", int'(cause_bo), int'(m_fbo));
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit to_thr, bit to_ctl, logic [CW-1:0] d);
        @(negedge clk);
        thr_we = to_thr; ctl_we = to_ctl; cfg_wdata = d;
        @(negedge clk);
        thr_we = 0; ctl_we = 0; cfg_wdata = '0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        // R1: reset state
        tick(3);
        @(posedge clk); #5 por_n = 1;
        // R4/R6: cold start with a one-cycle dropout mid-count
        tick(5);  supply_ok = 1;
        tick(8);  supply_ok = 0;
        tick(1);  supply_ok = 1;
        tick(20);
        // R8/R10: threshold write and power-up flag clear
        wr(1, 0, 6'h15);
        wr(0, 1, 6'h02);
        tick(2);
        // R5: short dip, minimum length dominates
        supply_ok = 0; tick(3); supply_ok = 1; tick(32);
        // R5/R6: long dip, valid delay dominates, dropout restarts count
        supply_ok = 0; tick(30); supply_ok = 1; tick(6);
        supply_ok = 0; tick(2);  supply_ok = 1; tick(20);
        // R10: brownout edge coincides with a clear of the brownout flag
        @(negedge clk); supply_ok = 0; ctl_we = 1; cfg_wdata = 6'h04;
        @(negedge clk); ctl_we = 0; cfg_wdata = '0;
        tick(2); supply_ok = 1; tick(30);
        wr(0, 1, 6'h04);
        tick(3);
        // R9: lock and code written together, then writes ignored
        @(negedge clk); thr_we = 1; ctl_we = 1; cfg_wdata = 6'h09;
        @(negedge clk); thr_we = 0; ctl_we = 0; cfg_wdata = '0;
        wr(1, 0, 6'h2A);
        wr(0, 1, 6'h06);
        wr(1, 1, 6'h3E);
        tick(3);
        // R1/R9: power cycle clears the lock and restores the default code
        @(posedge clk); #5 por_n = 0;
        tick(2);
        @(posedge clk); #5 por_n = 1;
        wr(1, 0, 6'h3F);
        tick(20);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end
endmodule